// File: doc/BRIEF.md
# Supervisor Return Frame Unwinder

This sequencer carries out a one-byte return-from-supervisor instruction, opcode 0x0F. Instruction fetch and decode happen outside the block, as do page mapping and the supervisor-call entry path. A one-cycle start strobe tells the block to run. It then does four things in order:

- It samples the caller-visible register values.
- It moves the program counter through the index register.
- It steps the stack pointer past the operand byte that the supervisor call left behind.
- It reads four saved bytes from a byte-wide stack and restores the interrupted context.

The block only issues reads and updates its register view. Memory answers each read through a ready handshake. The block holds the read address for as long as ready stays low. It signals completion with a single-cycle done pulse.

Top module: `rsv_unwinder`

## Requirements
- R1: In the cycle after an accepted start, `reg_p` holds the sampled `in_pc`, and both `reg_pc` and `reg_x` hold the sampled `in_x`.
- R2: The first stack read is at address `in_s + 1`. The byte at `in_s` is the skipped operand and is never read.
- R3: Four reads follow at consecutive rising addresses. They return, in order, the X high byte, the X low byte, the level byte and the map byte. The result is `reg_x = {byte0, byte1}`.
- R4: A read is a cycle with `mem_rd` high. While `mem_ready` is low, `mem_rd` and `mem_addr` stay unchanged and no byte is taken. A byte is captured only in a cycle with `mem_rd` and `mem_ready` both high.
- R5: When the map byte is captured, `reg_map` becomes that byte. `reg_isr` becomes {map[3:0], old isr[3:0]}: bits 7..4 take the map low nibble and bits 3..0 keep their value.
- R6: One cycle after the map update, `reg_lvl` takes the popped level byte. `done` is high for exactly that one cycle, and `mem_rd` is low while `done` is high.
- R7: `reg_s` advances by one after each captured byte, modulo 2^16. Its final value is `in_s + 5` mod 2^16.
- R8: A start strobe that arrives while a sequence runs is ignored. No register moves and the running sequence is unchanged.
- R9: Synchronous active-high `rst` returns the sequencer to idle, with `mem_rd` and `done` low. All register view outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| start | input | 1 | Begin the return sequence (used only when idle) |
| in_pc | input | 16 | Current program counter, sampled on start |
| in_x | input | 16 | Current index register, sampled on start |
| in_s | input | 16 | Current stack pointer, sampled on start |
| in_isr | input | 8 | Current interrupt status register, sampled on start |
| mem_rd | output | 1 | Stack read request |
| mem_addr | output | 16 | Stack read address |
| mem_data | input | 8 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Read completes in this cycle |
| reg_pc | output | 16 | Program counter view |
| reg_x | output | 16 | Index register view |
| reg_s | output | 16 | Stack pointer view |
| reg_p | output | 16 | Saved-PC register view |
| reg_map | output | 8 | Map register view |
| reg_isr | output | 8 | Interrupt status register view |
| reg_lvl | output | 8 | Current interrupt level view |
| done | output | 1 | One-cycle completion pulse |

## Verification
Most internal faults show at the ports one clock after the edge that caused them. A read counter that is off by one points `mem_addr` at the wrong slot on the very next read. A misrouted byte corrupts `reg_x`, `reg_lvl` or `reg_map` in the cycle after its capture. A state register that skips a step shifts or drops the `done` pulse. The bench runs a behavioural model in step with the block and compares every output on every clock. This catches a wrong address, a byte taken while not ready, or a start accepted while busy in the cycle where it first appears. Three patterns of ready timing are used, along with a stack pointer near the wrap point and a reset in mid-sequence.

// File: rtl/rsv_unwinder.sv
module rsv_unwinder (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] in_pc,
  input  logic [15:0] in_x,
  input  logic [15:0] in_s,
  input  logic [7:0]  in_isr,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_data,
  input  logic        mem_ready,
  output logic [15:0] reg_pc,
  output logic [15:0] reg_x,
  output logic [15:0] reg_s,
  output logic [15:0] reg_p,
  output logic [7:0]  reg_map,
  output logic [7:0]  reg_isr,
  output logic [7:0]  reg_lvl,
  output logic        done
);
  localparam int POPS = 4;
  localparam int IW   = $clog2(POPS);

  typedef enum logic [1:0] {IDLE, POP, LVL, FIN} st_t;
  st_t          st;
  logic [IW-1:0] idx;
  logic [7:0]    lvl_hold;

  wire take = (st == POP) && mem_ready;

  assign mem_rd   = (st == POP);
  assign mem_addr = reg_s;
  assign done     = (st == FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= IDLE;
      idx <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin st <= POP; idx <= '0; end
        POP:  if (mem_ready) begin
                idx <= idx + 1'b1;
                if (idx == IW'(POPS-1)) st <= LVL;
              end
        LVL:  st <= FIN;
        FIN:  st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (st == IDLE && start) begin
        reg_p   <= in_pc;
        reg_pc  <= in_x;
        reg_x   <= in_x;
        reg_s   <= in_s + 16'd1;
        reg_isr <= in_isr;
      end
      if (take) begin
        reg_s <= reg_s + 16'd1;
        case (idx)
          2'd0: reg_x[15:8] <= mem_data;
          2'd1: reg_x[7:0]  <= mem_data;
          2'd2: lvl_hold    <= mem_data;
          default: begin
            reg_map <= mem_data;
            reg_isr <= {mem_data[3:0], reg_isr[3:0]};
          end
        endcase
      end
      if (st == LVL) reg_lvl <= lvl_hold;
    end
  end

  AST_ADDR_HOLD:  assert property (@(posedge clk) disable iff (rst)
                    mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr)); // R4
  AST_S_STEP:     assert property (@(posedge clk) disable iff (rst)
                    mem_rd && mem_ready |=> reg_s == $past(reg_s) + 16'd1); // R7
  AST_ISR_LOW:    assert property (@(posedge clk) disable iff (rst)
                    mem_rd |=> $stable(reg_isr[3:0])); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
                    done |=> !done); // R6
  AST_DONE_NORD:  assert property (@(posedge clk) disable iff (rst)
                    done |-> !mem_rd); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
                    mem_rd && start |=> $stable(reg_p) && $stable(reg_pc)); // R8
endmodule

// File: tb/tb_rsv_unwinder.sv
module tb_rsv_unwinder;
  logic clk = 0, rst = 1, start = 0, mem_ready = 0;
  logic [15:0] in_pc = 0, in_x = 0, in_s = 0;
  logic [7:0]  in_isr = 0, mem_data;
  logic mem_rd, done;
  logic [15:0] mem_addr, reg_pc, reg_x, reg_s, reg_p;
  logic [7:0]  reg_map, reg_isr, reg_lvl;

  int compared = 0, mismatched = 0, mode = 0;
  bit finished = 0;

  rsv_unwinder dut (.*);

  always #10 clk = ~clk;

  function automatic logic [7:0] stack_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign mem_data = stack_byte(mem_addr);

  // behavioural model: step 0 idle, 1 reading, 2 level, 3 done
  int step = 0, k = 0;
  bit rv = 0, lv = 0;
  logic [15:0] m_pc, m_x, m_s, m_p;
  logic [7:0]  m_map, m_isr, m_lvl, m_lh, b;

  always @(posedge clk) begin
    if (rst) begin step = 0; k = 0; end
    else case (step)
      0: if (start) begin
           m_p = in_pc; m_pc = in_x; m_x = in_x; m_s = in_s + 16'd1; m_isr = in_isr;
           step = 1; k = 0; rv = 1;
         end
      1: if (mem_ready) begin
           b = stack_byte(m_s); m_s = m_s + 16'd1;
           if (k == 0) m_x[15:8] = b;
           else if (k == 1) m_x[7:0] = b;
           else if (k == 2) m_lh = b;
           else begin m_map = b; m_isr = {b[3:0], m_isr[3:0]}; step = 2; end
           k++;
         end
      2: begin m_lvl = m_lh; step = 3; lv = 1; end
      default: step = 0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(mem_rd === (step == 1), "R4 mem_rd", 16'(mem_rd), 16'(step == 1));
    chk(done === (step == 3), "R6 done", 16'(done), 16'(step == 3));
    if (step == 1) chk(mem_addr === m_s, "R2/R3 mem_addr", mem_addr, m_s);
    if (rv) begin
      chk(reg_p === m_p, "R1 reg_p", reg_p, m_p);
      chk(reg_pc === m_pc, "R1 reg_pc", reg_pc, m_pc);
      chk(reg_x === m_x, "R3 reg_x", reg_x, m_x);
      chk(reg_s === m_s, "R7 reg_s", reg_s, m_s);
      chk(reg_isr === m_isr, "R5 reg_isr", 16'(reg_isr), 16'(m_isr));
    end
    if (lv) begin
      chk(reg_map === m_map, "R5 reg_map", 16'(reg_map), 16'(m_map));
      chk(reg_lvl === m_lvl, "R6 reg_lvl", 16'(reg_lvl), 16'(m_lvl));
    end
  end

  always @(negedge clk)
    case (mode)
      0: mem_ready <= 1;
      1: mem_ready <= 1'($urandom % 2);
      default: mem_ready <= ($urandom % 4 == 0);
    endcase

  task automatic run_op(input logic [15:0] pc, x, s, input logic [7:0] isr, input int md, input bit poke);
    @(negedge clk);
    mode = md; in_pc = pc; in_x = x; in_s = s; in_isr = isr; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin // R8: second start while busy must be ignored
      in_pc = ~pc; in_x = ~x; in_s = ~s; start = 1;
      @(negedge clk); start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_rd === 0 && done === 0, "R9 reset idle", 16'({mem_rd, done}), 16'h0);
    rst = 0;
    run_op(16'h1234, 16'h8000, 16'h0100, 8'hA7, 0, 0);
    chk(reg_s === 16'h0105, "R7 final S", reg_s, 16'h0105);
    run_op(16'hBEEF, 16'h4321, 16'h2000, 8'h3C, 1, 0);
    run_op(16'h0042, 16'h7777, 16'hFFFC, 8'hF0, 2, 0);
    chk(reg_s === 16'h0001, "R7 wrap", reg_s, 16'h0001);
    run_op(16'hCAFE, 16'h0F0F, 16'h3000, 8'h5E, 2, 1);
    // R9: reset in mid-sequence keeps registers
    @(negedge clk); mode = 2; in_pc = 16'h1111; in_x = 16'h2222; in_s = 16'h4000; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk(mem_rd === 0 && done === 0, "R9 reset mid-run", 16'({mem_rd, done}), 16'h0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20; i++)
      run_op(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), i % 3, i % 4 == 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1; compared++; mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule